// File: doc/BRIEF.md
# Nibble-Stream Bootstrap Loader

This block turns a byte stream, typically the output of a serial receiver, into writes to a 4096-word control store. Only the low nibble of each byte carries information. The block slides every received nibble through a 16-bit window until the window holds the sync pattern. It then reads a 16-bit base address and a 16-bit word count, and writes that many 16-bit words into the store.

The words go to descending addresses. The first word goes one below the base, and each following word goes one lower again. A count of zero finishes the load at once. If the stream ends before the count is satisfied, the block flags a format error and returns to hunting for sync.

Top module: `nbl_boot_loader`

## Requirements
- R1: Only bits [3:0] of each accepted byte are used. Bits [7:4] have no effect on the sync match, the address, the count or the data.
- R2: Each accepted nibble shifts into a 16-bit window at the least significant end, so the oldest nibble sits at the most significant end. Sync is found when the window equals 16'hCF7F (octal 147577), whatever the nibble alignment of the preceding junk.
- R3: After sync, the next four nibbles form the base address and the following four form the count, each most significant nibble first.
- R4: Data word i, for i from 1 to count, is written to (base − i) truncated to 12 bits, so base 16'h5001 writes to 12'h000 and then 12'hFFF.
- R5: Each data word is built from four nibbles, most significant first, and appears on cs_data_o during its write.
- R6: A count of zero produces no write and a done_o pulse in the cycle after the fourth count nibble is accepted.
- R7: done_o is a single-cycle pulse in the cycle after the last write of a block.
- R8: eos_i asserted during address, count or data reception sets fmt_err_o. The block then returns to hunting, and no further write occurs until a new sync is found. fmt_err_o stays high until the next sync match. eos_i during hunting has no effect.
- R9: A word is written (cs_we_o high for exactly one cycle) in the cycle after its fourth nibble is accepted. byte_ready_o is low in that cycle.
- R10: eos_i in the cycle of the final write of a block does not raise fmt_err_o. The block completes normally with done_o.
- R11: After reset, byte_ready_o is 1, and cs_we_o, done_o and fmt_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received byte; low nibble used |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| eos_i | input | 1 | End of input stream |
| cs_we_o | output | 1 | Control-store write strobe |
| cs_addr_o | output | 12 | Control-store write address |
| cs_data_o | output | 16 | Control-store write data |
| done_o | output | 1 | Load completed (one cycle) |
| fmt_err_o | output | 1 | Stream ended before the count was met |

## Verification
End of stream and the final store write can fall in the same cycle. In that case completion must win, giving done_o and no error. The bench provokes this by asserting eos_i in exactly the write cycle that follows the last data nibble. It then judges the outcome by the done pulse and by fmt_err_o staying low. A contrasting case asserts eos_i two nibbles into a later word of a longer block. That case must raise fmt_err_o, and the scoreboard must see no stray write.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_BASE,
    ST_COUNT,
    ST_DATA,
    ST_WRITE
  } nbl_state_e;
endpackage

// File: rtl/nbl_nib_shift.sv
module nbl_nib_shift #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] win_nxt_o,
  output logic              word_done_o
);
  localparam int NPW = WORD_W / NIB_W;
  localparam int CW  = $clog2(NPW);

  logic [WORD_W-1:0] win_q;
  logic [CW-1:0]     cnt_q;
  logic              unused_hi;

  assign unused_hi   = ^byte_i[BYTE_W-1:NIB_W];
  assign win_nxt_o   = {win_q[WORD_W-NIB_W-1:0], byte_i[NIB_W-1:0]};
  assign word_done_o = shift_i && (cnt_q == CW'(NPW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      win_q <= win_nxt_o;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nbl_store_ptr.sv
module nbl_store_ptr #(
  parameter int WORD_W = 16,
  parameter int CS_AW  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_ld_i,
  input  logic              cnt_ld_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CS_AW-1:0]  wr_addr_o,
  output logic              last_o
);
  logic [WORD_W-1:0] ptr_q, rem_q, ptr_m1;

  assign ptr_m1    = ptr_q - 1'b1;
  assign wr_addr_o = ptr_m1[CS_AW-1:0];
  assign last_o    = (rem_q == WORD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rem_q <= '0;
    end else begin
      if (base_ld_i)   ptr_q <= word_i;
      else if (step_i) ptr_q <= ptr_m1;
      if (cnt_ld_i)    rem_q <= word_i;
      else if (step_i) rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/nbl_boot_loader.sv
module nbl_boot_loader
  import nbl_pkg::*;
#(
  parameter int                BYTE_W = 8,
  parameter int                NIB_W  = 4,
  parameter int                WORD_W = 16,
  parameter int                CS_AW  = 12,
  parameter logic [WORD_W-1:0] SYNC   = 16'o147577
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic              eos_i,
  output logic              cs_we_o,
  output logic [CS_AW-1:0]  cs_addr_o,
  output logic [WORD_W-1:0] cs_data_o,
  output logic              done_o,
  output logic              fmt_err_o
);
  nbl_state_e        state_q, state_d;
  logic [WORD_W-1:0] win_nxt, data_q;
  logic              accept, word_done, sync_hit, abort, last;
  logic              in_rx, done_q, err_q;

  assign byte_ready_o = (state_q != ST_WRITE);
  assign accept       = byte_valid_i && byte_ready_o;
  assign in_rx        = (state_q == ST_BASE) || (state_q == ST_COUNT) || (state_q == ST_DATA);
  assign sync_hit     = (state_q == ST_HUNT) && accept && (win_nxt == SYNC);
  // final write wins over end of stream
  assign abort        = eos_i && (in_rx || (state_q == ST_WRITE && !last));

  nbl_nib_shift #(.BYTE_W(BYTE_W), .NIB_W(NIB_W), .WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .shift_i     (accept),
    .clear_i     (sync_hit || abort),
    .win_nxt_o   (win_nxt),
    .word_done_o (word_done)
  );

  nbl_store_ptr #(.WORD_W(WORD_W), .CS_AW(CS_AW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_ld_i (state_q == ST_BASE && word_done && !abort),
    .cnt_ld_i  (state_q == ST_COUNT && word_done && !abort),
    .step_i    (state_q == ST_WRITE),
    .word_i    (win_nxt),
    .wr_addr_o (cs_addr_o),
    .last_o    (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:  if (sync_hit) state_d = ST_BASE;
      ST_BASE:  if (abort) state_d = ST_HUNT;
                else if (word_done) state_d = ST_COUNT;
      ST_COUNT: if (abort) state_d = ST_HUNT;
                else if (word_done) state_d = (win_nxt == '0) ? ST_HUNT : ST_DATA;
      ST_DATA:  if (abort) state_d = ST_HUNT;
                else if (word_done) state_d = ST_WRITE;
      ST_WRITE: state_d = (last || abort) ? ST_HUNT : ST_DATA;
      default:  state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DATA && word_done) data_q <= win_nxt;
      done_q <= (state_q == ST_WRITE && last) ||
                (state_q == ST_COUNT && word_done && !abort && win_nxt == '0);
      if (abort)         err_q <= 1'b1;
      else if (sync_hit) err_q <= 1'b0;
    end
  end

  assign cs_we_o   = (state_q == ST_WRITE);
  assign cs_data_o = data_q;
  assign done_o    = done_q;
  assign fmt_err_o = err_q;
endmodule

// File: rtl/nbl_boot_loader_chk.sv
module nbl_boot_loader_chk #(
  parameter int CS_AW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_ready_o,
  input logic             cs_we_o,
  input logic [CS_AW-1:0] cs_addr_o,
  input logic             done_o,
  input logic             fmt_err_o
);
  logic             in_blk_q;
  logic [CS_AW-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_blk_q <= 1'b0;
      prev_q   <= '0;
    end else if (done_o || fmt_err_o) begin
      in_blk_q <= 1'b0;
    end else if (cs_we_o) begin
      in_blk_q <= 1'b1;
      prev_q   <= cs_addr_o;
    end
  end

  // R4
  desc_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_we_o && in_blk_q) |-> (cs_addr_o == prev_q - 1'b1));
  // R9
  stall_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |-> !byte_ready_o);
  // R9
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |=> !cs_we_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  no_write_in_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> !cs_we_o);
  // R10
  done_not_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$rose(fmt_err_o));
endmodule

bind nbl_boot_loader nbl_boot_loader_chk #(.CS_AW(CS_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_ready_o (byte_ready_o),
  .cs_we_o      (cs_we_o),
  .cs_addr_o    (cs_addr_o),
  .done_o       (done_o),
  .fmt_err_o    (fmt_err_o)
);

// File: tb/nbl_boot_loader_test.sv
module nbl_boot_loader_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        eos_i = 1'b0;
  logic        byte_ready_o, cs_we_o, done_o, fmt_err_o;
  logic [11:0] cs_addr_o;
  logic [15:0] cs_data_o;

  int n_run = 0, n_fail = 0, n_done = 0;
  logic [27:0] exp_q[$];
  logic        prev_we = 1'b0, prev_done = 1'b0, zero_ok = 1'b0;
  logic [3:0]  hi_pat = 4'h0;

  always #10 clk_i = ~clk_i;

  nbl_boot_loader uut (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (cs_we_o) begin
      chk(!byte_ready_o, "R9 ready during write", 32'(byte_ready_o), 0);
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected write", {4'h0, cs_addr_o, cs_data_o}, 0);
      else begin
        logic [27:0] e;
        e = exp_q.pop_front();
        chk(cs_addr_o == e[27:16], "R4 write address", 32'(cs_addr_o), 32'(e[27:16]));
        chk(cs_data_o == e[15:0], "R5 write data", 32'(cs_data_o), 32'(e[15:0]));
      end
    end
    if (done_o) begin
      n_done++;
      chk(!prev_done, "R7 done width", 1, 0);
      chk(prev_we || zero_ok, "R7 done after last write", 32'(prev_we), 1);
    end
    prev_we   = cs_we_o;
    prev_done = done_o;
  end

  task automatic send_nib(input logic [3:0] n);
    @(negedge clk_i);
    hi_pat = hi_pat + 4'h5;
    byte_i = {hi_pat, n};
    byte_valid_i = 1'b1;
    while (!byte_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #2 byte_valid_i = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int k = 3; k >= 0; k--) send_nib(w[k*4 +: 4]);
  endtask

  // driver: pushes expected writes, sends header and payload
  task automatic send_block(input logic [15:0] base, input logic [15:0] wds[$]);
    send_word(16'hCF7F);
    send_word(base);
    send_word(16'(wds.size()));
    for (int i = 0; i < wds.size(); i++) begin
      logic [15:0] a;
      a = base - 16'(i + 1);
      exp_q.push_back({a[11:0], wds[i]});
      send_word(wds[i]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk_i);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    idle(2);
    #3 rst_ni = 1'b1;
    @(negedge clk_i);
    // R11
    chk(byte_ready_o && !cs_we_o && !done_o && !fmt_err_o, "R11 reset state",
        {byte_ready_o, cs_we_o, done_o, fmt_err_o}, 4'b1000);

    // R1 R2 R3: junk with misalignment, upper bits vary on every byte
    send_nib(4'h3); send_nib(4'hC); send_nib(4'hF); send_nib(4'h7);
    send_block(16'h0103, '{16'h1234, 16'hABCD, 16'h0F0F});
    idle(3);
    chk(n_done == 1, "R7 done count block1", n_done, 1);
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    // R4 truncation and wrap below zero
    send_block(16'h5001, '{16'hBEEF, 16'h8001});
    idle(3);
    chk(n_done == 2, "R4 done count block2", n_done, 2);
    chk(exp_q.size() == 0, "R4 wrap writes seen", exp_q.size(), 0);

    // R6 zero count
    zero_ok = 1'b1;
    send_word(16'hCF7F); send_word(16'h0800); send_word(16'h0000);
    idle(3);
    zero_ok = 1'b0;
    chk(n_done == 3, "R6 zero count done", n_done, 3);

    // R8 eos while hunting is ignored
    send_nib(4'h1);
    @(negedge clk_i); eos_i = 1'b1;
    @(negedge clk_i); eos_i = 1'b0;
    idle(1);
    chk(!fmt_err_o, "R8 eos in hunt ignored", 32'(fmt_err_o), 0);

    // R8 abort mid data
    send_word(16'hCF7F); send_word(16'h0200); send_word(16'h0003);
    exp_q.push_back({12'h1FF, 16'h5555});
    send_word(16'h5555);
    send_nib(4'h6); send_nib(4'h6);
    @(negedge clk_i); eos_i = 1'b1;
    @(negedge clk_i); eos_i = 1'b0;
    idle(1);
    chk(fmt_err_o, "R8 error raised", 32'(fmt_err_o), 1);
    send_nib(4'h6); send_nib(4'h6); send_word(16'h7777);
    idle(3);
    chk(fmt_err_o, "R8 error sticky", 32'(fmt_err_o), 1);
    chk(n_done == 3, "R8 no done after abort", n_done, 3);
    send_word(16'hCF7F);
    idle(1);
    chk(!fmt_err_o, "R8 error cleared by sync", 32'(fmt_err_o), 0);

    // R10 eos in the final write cycle
    send_word(16'h0040); send_word(16'h0001);
    exp_q.push_back({12'h03F, 16'hC0DE});
    send_word(16'hC0DE);
    @(negedge clk_i); eos_i = 1'b1;
    @(negedge clk_i); eos_i = 1'b0;
    idle(2);
    chk(n_done == 4, "R10 done with eos", n_done, 4);
    chk(!fmt_err_o, "R10 no error", 32'(fmt_err_o), 0);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule